// File: doc/BRIEF.md
# Load Value Prediction Classification Table

This block keeps, per table slot, the most recently loaded data value of a load instruction together with a four-level confidence class. A pipeline asks it, using the load's instruction address, whether that load's result can be guessed. The block then answers with the class, the remembered value and the slot number. Only the two upper classes allow the value to be forwarded. The top class additionally marks the load as one that may skip memory.

When the true value of a load becomes known, the pipeline presents it on the update port. The block compares it with the remembered value and moves the class one level up on agreement or one level down on disagreement. It always stores the new value. When a slot climbs into the top class, the block emits a one-cycle request carrying the slot number, so that separate constant-tracking logic can record it. The table is tagless and direct-mapped, and there is no valid bit: the two lowest classes simply produce no prediction.

Top module: `load_value_class_table`

## Requirements
- R1: After reset every slot reads back class 0 (lowest unpredictable level) with value 0, and gives no prediction. Class encoding: 0 = unpredictable-low, 1 = unpredictable-high, 2 = predictable, 3 = constant.
- R2: A lookup presented in cycle N yields rsp_valid high in cycle N+1, together with the slot's class, its value, and rsp_index equal to lk_pc[11:2]. rsp_valid is low in any cycle that follows a cycle without a lookup.
- R3: rsp_predict is high only for class 2 or 3. rsp_bypass is high only for class 3.
- R4: An update whose value equals the stored value raises the class one level, saturating at 3.
- R5: An update whose value differs from the stored value lowers the class one level, saturating at 0.
- R6: Every update replaces the stored value with the update value.
- R7: An update that moves a slot from class 2 to class 3 sets ins_valid high for exactly the next cycle, with ins_index equal to up_pc[11:2]. An update that leaves a slot at 3 does not set ins_valid.
- R8: When a lookup and an update hit the same slot in one cycle, the lookup returns the contents as they were before that update.
- R9: Addresses that differ only above bit 11 or below bit 2 share one slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| lk_valid | input | 1 | Lookup request |
| lk_pc | input | 32 | Instruction address of the load being looked up |
| rsp_valid | output | 1 | Lookup answer present |
| rsp_class | output | 2 | Class of the addressed slot |
| rsp_value | output | 64 | Stored value of the addressed slot |
| rsp_index | output | 10 | Slot number of the answer |
| rsp_predict | output | 1 | Value may be forwarded |
| rsp_bypass | output | 1 | Load is classed constant and may skip memory |
| up_valid | input | 1 | Update request |
| up_pc | input | 32 | Instruction address of the completed load |
| up_value | input | 64 | True loaded value |
| ins_valid | output | 1 | Slot just reached the constant class |
| ins_index | output | 10 | Slot number for ins_valid |

## Verification
On every cycle, the assertions check the following: the answer timing and slot number against the earlier request, that a bypass always comes with a prediction, and that each update moves the class by at most one level. They also check that an insert request always follows an update of the same slot whose class went from predictable to constant. What the class actually reaches after a chosen sequence of matching and differing values, how it saturates at both ends, that aliased addresses share a slot, and that a colliding lookup sees the old contents can only be shown by the bench's scenarios.

// File: rtl/lvct_pkg.sv
package lvct_pkg;
  typedef enum logic [1:0] {
    CONF_WEAK0 = 2'd0,
    CONF_WEAK1 = 2'd1,
    CONF_PRED  = 2'd2,
    CONF_CONST = 2'd3
  } conf_e;

  function automatic conf_e conf_next(input conf_e cur, input logic agree);
    conf_e res;
    res = cur;
    if (agree) begin
      if (cur != CONF_CONST) res = conf_e'(cur + 2'd1);
    end else begin
      if (cur != CONF_WEAK0) res = conf_e'(cur - 2'd1);
    end
    return res;
  endfunction

  function automatic logic conf_forwards(input conf_e c);
    return (c == CONF_PRED) || (c == CONF_CONST);
  endfunction

  function automatic logic conf_skips_mem(input conf_e c);
    return c == CONF_CONST;
  endfunction
endpackage

// File: rtl/lvct_index.sv
module lvct_index #(
  parameter int PC_W    = 32,
  parameter int OFF_LSB = 2,
  parameter int IDX_W   = 10
) (
  input  logic [PC_W-1:0]  pc,
  output logic [IDX_W-1:0] idx
);
  localparam int HI = OFF_LSB + IDX_W - 1;
  logic pc_unused;
  assign idx = pc[HI:OFF_LSB];
  assign pc_unused = ^{pc[PC_W-1:HI+1], pc[OFF_LSB-1:0]};
endmodule

// File: rtl/lvct_store.sv
module lvct_store
  import lvct_pkg::*;
#(
  parameter int ENTRIES = 1024,
  parameter int VAL_W   = 64,
  parameter int IDX_W   = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_en,
  input  logic [IDX_W-1:0] rd_idx,
  output conf_e            rd_cls,
  output logic [VAL_W-1:0] rd_val,
  input  logic [IDX_W-1:0] mod_idx,
  output conf_e            mod_cls,
  output logic [VAL_W-1:0] mod_val,
  input  logic             wr_en,
  input  conf_e            wr_cls,
  input  logic [VAL_W-1:0] wr_val
);
  conf_e            cls_mem [ENTRIES];
  logic [VAL_W-1:0] val_mem [ENTRIES];

  assign mod_cls = cls_mem[mod_idx];
  assign mod_val = val_mem[mod_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) begin
        cls_mem[i] <= CONF_WEAK0;
        val_mem[i] <= '0;
      end
    end else if (wr_en) begin
      cls_mem[mod_idx] <= wr_cls;
      val_mem[mod_idx] <= wr_val;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_cls <= CONF_WEAK0;
      rd_val <= '0;
    end else if (rd_en) begin
      rd_cls <= cls_mem[rd_idx];
      rd_val <= val_mem[rd_idx];
    end
  end
endmodule

// File: rtl/lvct_update.sv
module lvct_update
  import lvct_pkg::*;
#(
  parameter int VAL_W = 64
) (
  input  conf_e            old_cls,
  input  logic [VAL_W-1:0] old_val,
  input  logic [VAL_W-1:0] true_val,
  output conf_e            new_cls,
  output logic             agree,
  output logic             reach_const
);
  assign agree       = (old_val == true_val);
  assign new_cls     = conf_next(old_cls, agree);
  assign reach_const = conf_skips_mem(new_cls) && !conf_skips_mem(old_cls);
endmodule

// File: rtl/load_value_class_table.sv
module load_value_class_table
  import lvct_pkg::*;
#(
  parameter int ENTRIES = 1024,
  parameter int VAL_W   = 64,
  parameter int PC_W    = 32,
  parameter int OFF_LSB = 2,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lk_valid,
  input  logic [PC_W-1:0]  lk_pc,
  output logic             rsp_valid,
  output logic [1:0]       rsp_class,
  output logic [VAL_W-1:0] rsp_value,
  output logic [IDX_W-1:0] rsp_index,
  output logic             rsp_predict,
  output logic             rsp_bypass,
  input  logic             up_valid,
  input  logic [PC_W-1:0]  up_pc,
  input  logic [VAL_W-1:0] up_value,
  output logic             ins_valid,
  output logic [IDX_W-1:0] ins_index
);
  logic [IDX_W-1:0] lk_idx, up_idx;
  conf_e            rd_cls, upd_old_cls, upd_new_cls;
  logic [VAL_W-1:0] upd_old_val;
  logic             upd_agree, upd_reach;

  lvct_index #(.PC_W(PC_W), .OFF_LSB(OFF_LSB), .IDX_W(IDX_W)) u_lk_idx (
    .pc(lk_pc), .idx(lk_idx));
  lvct_index #(.PC_W(PC_W), .OFF_LSB(OFF_LSB), .IDX_W(IDX_W)) u_up_idx (
    .pc(up_pc), .idx(up_idx));

  lvct_store #(.ENTRIES(ENTRIES), .VAL_W(VAL_W), .IDX_W(IDX_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .rd_en(lk_valid), .rd_idx(lk_idx), .rd_cls(rd_cls), .rd_val(rsp_value),
    .mod_idx(up_idx), .mod_cls(upd_old_cls), .mod_val(upd_old_val),
    .wr_en(up_valid), .wr_cls(upd_new_cls), .wr_val(up_value));

  lvct_update #(.VAL_W(VAL_W)) u_update (
    .old_cls(upd_old_cls), .old_val(upd_old_val), .true_val(up_value),
    .new_cls(upd_new_cls), .agree(upd_agree), .reach_const(upd_reach));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_index <= '0;
      ins_valid <= 1'b0;
      ins_index <= '0;
    end else begin
      rsp_valid <= lk_valid;
      if (lk_valid) rsp_index <= lk_idx;
      ins_valid <= up_valid && upd_reach;
      if (up_valid && upd_reach) ins_index <= up_idx;
    end
  end

  assign rsp_class   = rd_cls;
  assign rsp_predict = rsp_valid && conf_forwards(rd_cls);
  assign rsp_bypass  = rsp_valid && conf_skips_mem(rd_cls);
endmodule

// File: rtl/lvct_checker.sv
module lvct_checker #(
  parameter int PC_W    = 32,
  parameter int OFF_LSB = 2,
  parameter int IDX_W   = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             lk_valid,
  input logic [PC_W-1:0]  lk_pc,
  input logic             rsp_valid,
  input logic [IDX_W-1:0] rsp_index,
  input logic             rsp_predict,
  input logic             rsp_bypass,
  input logic             up_valid,
  input logic [PC_W-1:0]  up_pc,
  input logic             ins_valid,
  input logic [IDX_W-1:0] ins_index,
  input logic [1:0]       old_cls,
  input logic [1:0]       new_cls
);
  localparam int HI = OFF_LSB + IDX_W - 1;

  p_rsp_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(lk_valid) |-> rsp_valid);
  p_rsp_needs_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(lk_valid));
  p_rsp_slot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> rsp_index == $past(lk_pc[HI:OFF_LSB]));
  p_bypass_implies_predict_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_bypass |-> rsp_predict);
  p_step_one_r4: assert property (@(posedge clk) disable iff (!rst_n)
    up_valid |-> ((new_cls == old_cls) || (new_cls == old_cls + 2'd1)
                  || (new_cls + 2'd1 == old_cls)));
  p_no_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    up_valid |-> !((old_cls == 2'd0 && new_cls == 2'd3) || (old_cls == 2'd3 && new_cls == 2'd0)));
  p_ins_after_reach_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ins_valid |-> $past(up_valid) && $past(old_cls) == 2'd2 && $past(new_cls) == 2'd3);
  p_ins_slot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ins_valid |-> ins_index == $past(up_pc[HI:OFF_LSB]));
endmodule

bind load_value_class_table lvct_checker #(.PC_W(PC_W), .OFF_LSB(OFF_LSB), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_pc(lk_pc),
  .rsp_valid(rsp_valid), .rsp_index(rsp_index), .rsp_predict(rsp_predict),
  .rsp_bypass(rsp_bypass), .up_valid(up_valid), .up_pc(up_pc),
  .ins_valid(ins_valid), .ins_index(ins_index),
  .old_cls(upd_old_cls), .new_cls(upd_new_cls));

// File: tb/load_value_class_table_tb.sv
module load_value_class_table_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lk_valid = 1'b0;
  logic [31:0] lk_pc = '0;
  logic        rsp_valid;
  logic [1:0]  rsp_class;
  logic [63:0] rsp_value;
  logic [9:0]  rsp_index;
  logic        rsp_predict, rsp_bypass;
  logic        up_valid = 1'b0;
  logic [31:0] up_pc = '0;
  logic [63:0] up_value = '0;
  logic        ins_valid;
  logic [9:0]  ins_index;

  int n_chk = 0, n_bad = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  load_value_class_table u_dut (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_pc(lk_pc),
    .rsp_valid(rsp_valid), .rsp_class(rsp_class), .rsp_value(rsp_value),
    .rsp_index(rsp_index), .rsp_predict(rsp_predict), .rsp_bypass(rsp_bypass),
    .up_valid(up_valid), .up_pc(up_pc), .up_value(up_value),
    .ins_valid(ins_valid), .ins_index(ins_index));

  typedef struct packed {
    logic [31:0] pc;
    logic [63:0] val;
    logic [1:0]  cls;
    logic [63:0] eval;
    logic        ins;
  } vec_t;

  localparam logic [31:0] PA = 32'h0000_0104;
  localparam int NV = 11;
  // Each vector: update pc with val, then look up pc; expected class, value, insert pulse.
  localparam vec_t VEC [NV] = '{
    '{PA, 64'd5, 2'd0, 64'd5, 1'b0},   // differs from reset value 0: stays at 0
    '{PA, 64'd5, 2'd1, 64'd5, 1'b0},
    '{PA, 64'd5, 2'd2, 64'd5, 1'b0},
    '{PA, 64'd5, 2'd3, 64'd5, 1'b1},   // reaches constant
    '{PA, 64'd5, 2'd3, 64'd5, 1'b0},   // saturates, no new insert
    '{PA, 64'd7, 2'd2, 64'd7, 1'b0},
    '{PA, 64'd7, 2'd3, 64'd7, 1'b1},
    '{PA, 64'd9, 2'd2, 64'd9, 1'b0},
    '{PA, 64'd1, 2'd1, 64'd1, 1'b0},
    '{PA, 64'd2, 2'd0, 64'd2, 1'b0},
    '{PA, 64'd3, 2'd0, 64'd3, 1'b0}    // saturates at bottom
  };

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_update(input logic [31:0] pc, input logic [63:0] v);
    @(negedge clk);
    up_valid = 1'b1; up_pc = pc; up_value = v;
    @(negedge clk);
    up_valid = 1'b0;
  endtask

  task automatic do_lookup(input logic [31:0] pc);
    @(negedge clk);
    lk_valid = 1'b1; lk_pc = pc;
    @(negedge clk);
    lk_valid = 1'b0;
  endtask

  task automatic check_rsp(input string tag, input logic [31:0] pc, input logic [1:0] ec, input logic [63:0] ev);
    chk(rsp_valid == 1'b1, {tag, " R2 rsp_valid"}, 64'(rsp_valid), 64'd1);
    chk(rsp_index == pc[11:2], {tag, " R2 rsp_index"}, 64'(rsp_index), 64'(pc[11:2]));
    chk(rsp_class == ec, {tag, " R4 R5 class"}, 64'(rsp_class), 64'(ec));
    chk(rsp_value == ev, {tag, " R6 value"}, rsp_value, ev);
    chk(rsp_predict == (ec >= 2'd2), {tag, " R3 predict"}, 64'(rsp_predict), 64'(ec >= 2'd2));
    chk(rsp_bypass == (ec == 2'd3), {tag, " R3 bypass"}, 64'(rsp_bypass), 64'(ec == 2'd3));
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rsp_valid == 1'b0 && ins_valid == 1'b0, "R1 R2 idle after reset", 64'({rsp_valid, ins_valid}), 64'd0);

    // R1: untouched slots read class 0, value 0
    do_lookup(32'h0000_0200);
    check_rsp("R1 reset slot", 32'h0000_0200, 2'd0, 64'd0);
    do_lookup(32'h0000_0FFC);
    check_rsp("R1 top slot", 32'h0000_0FFC, 2'd0, 64'd0);
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R2 no answer without lookup", 64'(rsp_valid), 64'd0);

    // Vector table: R4 R5 R6 R7
    for (int k = 0; k < NV; k++) begin
      do_update(VEC[k].pc, VEC[k].val);
      chk(ins_valid == VEC[k].ins, $sformatf("R7 vec%0d ins_valid", k), 64'(ins_valid), 64'(VEC[k].ins));
      if (VEC[k].ins)
        chk(ins_index == VEC[k].pc[11:2], $sformatf("R7 vec%0d ins_index", k), 64'(ins_index), 64'(VEC[k].pc[11:2]));
      @(negedge clk);
      chk(ins_valid == 1'b0, $sformatf("R7 vec%0d single pulse", k), 64'(ins_valid), 64'd0);
      do_lookup(VEC[k].pc);
      check_rsp($sformatf("vec%0d", k), VEC[k].pc, VEC[k].cls, VEC[k].eval);
    end

    // R9: alias above bit 11 and below bit 2 hits the same slot (slot holds class 0, value 3)
    do_update(PA + 32'h0000_1000, 64'd3);
    do_lookup(PA | 32'h0000_0003);
    check_rsp("R9 alias", PA, 2'd1, 64'd3);

    // R8: same-cycle lookup and update on one slot returns old contents
    do_update(32'h0000_0300, 64'h11);
    @(negedge clk);
    lk_valid = 1'b1; lk_pc = 32'h0000_0300;
    up_valid = 1'b1; up_pc = 32'h0000_0300; up_value = 64'h22;
    @(negedge clk);
    lk_valid = 1'b0; up_valid = 1'b0;
    check_rsp("R8 collision old", 32'h0000_0300, 2'd0, 64'h11);
    do_lookup(32'h0000_0300);
    check_rsp("R8 after collision", 32'h0000_0300, 2'd0, 64'h22);

    // R1: unrelated slot stays untouched
    do_lookup(32'h0000_0200);
    check_rsp("R1 untouched slot", 32'h0000_0200, 2'd0, 64'd0);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule